// File: doc/BRIEF.md
# Bit-Test and Carry-Rotate Flag Unit

This block is a small execution slice for a 16-bit processor. It carries out a non-destructive bit test: the source and destination operands are ANDed, the result is thrown away, and only the N, Z, C and V status flags are updated. Carry is set exactly when the AND result is non-zero. So a test whose mask holds a single bit copies the tested bit straight into carry.

The same unit holds a receive buffer and can rotate that buffer through carry, either right or left. Each rotate can work on the full word or on the low byte. A serial input is gathered by alternating two operations: a single-bit test of the receive line, then a rotate. After eight such pairs a whole byte sits in the buffer. The right rotate gives least-significant-bit-first order and the left rotate gives most-significant-bit-first order.

Every operation is started by a one-cycle strobe and finishes one clock later, when a one-cycle done pulse is raised.

Top module: `bittest_rotate_unit`

## Requirements
- R1: A test (op code 0) sets the flags from `src & dst` at the selected size and leaves the buffer unchanged.
- R2: After a test, N equals the most significant bit of the AND result: bit 7 when `byte_sel` is 1, bit 15 when it is 0.
- R3: After a test, Z is 1 exactly when the AND result at the selected size is zero, and C is always the inverse of Z.
- R4: V is 0 after every completed operation.
- R5: A test with exactly one mask bit set in `src` leaves C equal to that bit of `dst`.
- R6: A right rotate (op code 1) loads the old C into the buffer's top bit (bit 15 for a word, bit 7 for a byte), shifts every other bit down by one, and moves the old bit 0 into C. Eight test-then-rotate pairs on a byte collect a serial stream least-significant-bit first, with the first bit received ending in bit 0.
- R7: A left rotate (op code 2) loads the old C into bit 0, shifts every other bit up by one, and moves the old top bit of the selected size into C. Eight test-then-rotate pairs on a byte collect a serial stream most-significant-bit first, with the first bit received ending in bit 7.
- R8: A byte-size rotate clears buffer bits 15:8. It computes its result and its N and Z flags from the low 8 bits only. In every rotate, N and Z describe the rotated result.
- R9: `done` is high in the cycle after a cycle with `start` high, and only then. When `start` is low, the flags and the buffer hold their values.
- R10: A synchronous reset clears all four flags, the buffer and `done`.
- R11: Op code 3 is reserved. When started, it changes no flag and no buffer bit, but still pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts one operation this cycle |
| op | input | 2 | 0 test, 1 rotate right, 2 rotate left, 3 reserved |
| byte_sel | input | 1 | 1 selects byte size, 0 selects word size |
| src | input | 16 | Test mask operand |
| dst | input | 16 | Tested operand |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| buf_q | output | 16 | Receive buffer value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default widths, a 16-bit word and an 8-bit byte lane. With these widths the byte/word boundary falls at bit 7 versus bit 15, so the byte-mode behaviours can be seen at the ports:
- a mismatch in the N flag;
- the upper-byte clearing;
- a mis-chosen carry-out bit.

Random operands and operation sequences drive the unit against a bench model. Directed serial captures check both bit orders, and directed single-bit tests cover every mask position.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    OP_TEST = 2'd0,
    OP_RRC  = 2'd1,
    OP_RLC  = 2'd2,
    OP_RSVD = 2'd3
  } bt_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } bt_flags_t;
endpackage

// File: rtl/bt_test_unit.sv
module bt_test_unit
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output bt_flags_t         test_flags
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  function automatic logic [DATA_W-1:0] and_sized(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b,
                                                  input logic bsel);
    logic [DATA_W-1:0] r;
    r = a & b;
    if (bsel) r = r & LOW_MASK;
    return r;
  endfunction

  function automatic bt_flags_t flags_of_and(input logic [DATA_W-1:0] r,
                                             input logic bsel);
    bt_flags_t f;
    f.n = bsel ? r[BYTE_W-1] : r[DATA_W-1];
    f.z = (r == '0);
    f.c = (r != '0);
    f.v = 1'b0;
    return f;
  endfunction

  logic [DATA_W-1:0] and_res;

  always_comb begin
    and_res    = and_sized(src, dst, byte_sel);
    test_flags = flags_of_and(and_res, byte_sel);
  end
endmodule

// File: rtl/bt_rotate_unit.sv
module bt_rotate_unit
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              dir_left,
  input  logic              byte_sel,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] buf_in,
  output logic [DATA_W-1:0] buf_out,
  output bt_flags_t         rot_flags
);
  localparam int HI_W = DATA_W - BYTE_W;

  function automatic logic [BYTE_W-1:0] low_rot(input logic [BYTE_W-1:0] v,
                                                input logic cin, input logic left);
    return left ? {v[BYTE_W-2:0], cin} : {cin, v[BYTE_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] word_rot(input logic [DATA_W-1:0] v,
                                                 input logic cin, input logic left);
    return left ? {v[DATA_W-2:0], cin} : {cin, v[DATA_W-1:1]};
  endfunction

  function automatic logic carry_out(input logic [DATA_W-1:0] v,
                                     input logic left, input logic bsel);
    if (!left) return v[0];
    return bsel ? v[BYTE_W-1] : v[DATA_W-1];
  endfunction

  logic [DATA_W-1:0] word_res;
  logic [BYTE_W-1:0] byte_res;
  logic [DATA_W-1:0] byte_ext;

  always_comb begin
    word_res = word_rot(buf_in, carry_in, dir_left);
    byte_res = low_rot(buf_in[BYTE_W-1:0], carry_in, dir_left);
  end

  generate
    if (HI_W > 0) begin : g_ext
      assign byte_ext = {{HI_W{1'b0}}, byte_res};
    end else begin : g_noext
      assign byte_ext = byte_res;
    end
  endgenerate

  always_comb begin
    buf_out     = byte_sel ? byte_ext : word_res;
    rot_flags.c = carry_out(buf_in, dir_left, byte_sel);
    rot_flags.n = byte_sel ? byte_res[BYTE_W-1] : word_res[DATA_W-1];
    rot_flags.z = byte_sel ? (byte_res == '0) : (word_res == '0);
    rot_flags.v = 1'b0;
  end
endmodule

// File: rtl/bt_state_reg.sv
module bt_state_reg
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  bt_op_e            op,
  input  logic              byte_sel,
  input  bt_flags_t         test_flags,
  input  bt_flags_t         rot_flags,
  input  logic [DATA_W-1:0] rot_buf,
  output bt_flags_t         flags_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              done_q
);
  // named internal events for the checks below
  logic ev_test, ev_rot, ev_rsvd;
  bt_flags_t         flags_d;
  logic [DATA_W-1:0] buf_d;

  assign ev_test = start && (op == OP_TEST);
  assign ev_rot  = start && ((op == OP_RRC) || (op == OP_RLC));
  assign ev_rsvd = start && (op == OP_RSVD);

  always_comb begin
    flags_d = flags_q;
    buf_d   = buf_q;
    if (ev_test) begin
      flags_d = test_flags;
    end else if (ev_rot) begin
      flags_d = rot_flags;
      buf_d   = rot_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      buf_q   <= buf_d;
      done_q  <= start;
    end
  end

  AST_TEST_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    ev_test |=> $stable(buf_q)); // R1
  AST_TEST_C_NOT_Z: assert property (@(posedge clk) disable iff (rst)
    ev_test |=> (flags_q.c == !flags_q.z)); // R3
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ev_test || ev_rot) |=> !flags_q.v); // R4
  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ev_rot && byte_sel) |=> (buf_q[DATA_W-1:BYTE_W] == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(buf_q) && $stable(flags_q) && !done_q)); // R9
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_rsvd |=> ($stable(buf_q) && $stable(flags_q) && done_q)); // R11
endmodule

// File: rtl/bittest_rotate_unit.sv
module bittest_rotate_unit
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic [DATA_W-1:0] buf_q,
  output logic              done
);
  bt_op_e            op_e;
  bt_flags_t         test_flags, rot_flags, flags_q;
  logic [DATA_W-1:0] rot_buf;
  logic [DATA_W-1:0] buf_r;

  assign op_e = bt_op_e'(op);

  bt_test_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_test (
    .byte_sel  (byte_sel),
    .src       (src),
    .dst       (dst),
    .test_flags(test_flags)
  );

  bt_rotate_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rot (
    .dir_left (op_e == OP_RLC),
    .byte_sel (byte_sel),
    .carry_in (flags_q.c),
    .buf_in   (buf_r),
    .buf_out  (rot_buf),
    .rot_flags(rot_flags)
  );

  bt_state_reg #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op_e),
    .byte_sel  (byte_sel),
    .test_flags(test_flags),
    .rot_flags (rot_flags),
    .rot_buf   (rot_buf),
    .flags_q   (flags_q),
    .buf_q     (buf_r),
    .done_q    (done)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign buf_q  = buf_r;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R9
endmodule

// File: tb/bittest_rotate_unit_tb.sv
module bittest_rotate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, start, byte_sel;
  logic [1:0]  op;
  logic [15:0] src, dst;
  logic        flag_n, flag_z, flag_c, flag_v, done;
  logic [15:0] buf_q;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [15:0] m_buf;
  logic        m_n, m_z, m_c, m_v;

  always #5 clk = ~clk;

  bittest_rotate_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .byte_sel(byte_sel),
    .src(src), .dst(dst), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .buf_q(buf_q), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // model: bitwise loop, size as a bit count
  task automatic model_op(input logic [1:0] o, input logic b,
                          input logic [15:0] s, input logic [15:0] d);
    int w;
    logic [15:0] r;
    logic old_c;
    w = b ? 8 : 16;
    r = '0;
    if (o == 2'd0) begin
      for (int i = 0; i < w; i++) r[i] = s[i] & d[i];
      m_n = r[w-1]; m_z = (r == 0); m_c = (r != 0); m_v = 1'b0;
    end else if (o == 2'd1 || o == 2'd2) begin
      old_c = m_c;
      if (o == 2'd1) begin
        m_c = m_buf[0];
        for (int i = 0; i < w-1; i++) r[i] = m_buf[i+1];
        r[w-1] = old_c;
      end else begin
        m_c = m_buf[w-1];
        for (int i = 1; i < w; i++) r[i] = m_buf[i-1];
        r[0] = old_c;
      end
      m_buf = r;
      m_n = r[w-1]; m_z = (r == 0); m_v = 1'b0;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] o, input logic b,
                        input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; op = o; byte_sel = b; src = s; dst = d;
    model_op(o, b, s, d);
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, {31'd0, done}, 32'd1);
    chk({req, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, m_n, m_z, m_c, m_v});
    chk({req, " buf"}, {16'd0, buf_q}, {16'd0, m_buf});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0] pat;
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; op = 2'd0; byte_sel = 1'b0; src = '0; dst = '0;
    m_buf = '0; m_n = 0; m_z = 0; m_c = 0; m_v = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset", {15'd0, flag_n, flag_z, flag_c, flag_v, buf_q, done}, 32'd0);
    rst = 1'b0;

    // R2 R3 R4: directed tests at the size boundary
    run_op("R2 word msb", 2'd0, 1'b0, 16'h8000, 16'hFFFF);
    run_op("R2 byte msb", 2'd0, 1'b1, 16'h8080, 16'h8080);
    run_op("R3 byte upper ignored zero", 2'd0, 1'b1, 16'hFF00, 16'hFF00);
    run_op("R3 word zero", 2'd0, 1'b0, 16'h00F0, 16'h0F0F);
    run_op("R4 V after test", 2'd0, 1'b0, 16'h1234, 16'h1230);

    // R5: every single-bit mask position, both dst values
    for (int k = 0; k < 16; k++) begin
      run_op("R5 bit set", 2'd0, 1'b0, 16'h1 << k, 16'h1 << k);
      run_op("R5 bit clear", 2'd0, 1'b0, 16'h1 << k, ~(16'h1 << k));
    end

    // R1: test leaves buffer alone (load buffer via word rotates first)
    run_op("R1 prep", 2'd0, 1'b0, 16'h1, 16'h1);
    run_op("R1 prep", 2'd2, 1'b0, 16'h0, 16'h0);
    run_op("R1 keep buf", 2'd0, 1'b0, 16'hFFFF, 16'hAAAA);

    // R6: LSB-first serial capture with byte right rotate
    pat = 8'hA5;
    for (int i = 0; i < 8; i++) begin
      run_op("R6 sample", 2'd0, 1'b1, 16'h0008, {12'd0, pat[i], 3'd0});
      run_op("R6 shift", 2'd1, 1'b1, 16'h0, 16'h0);
    end
    chk("R6 lsb-first byte", {16'd0, buf_q}, {24'd0, pat});

    // R7: MSB-first serial capture with byte left rotate
    pat = 8'h3C;
    for (int i = 7; i >= 0; i--) begin
      run_op("R7 sample", 2'd0, 1'b1, 16'h0040, {9'd0, pat[i], 6'd0});
      run_op("R7 shift", 2'd2, 1'b1, 16'h0, 16'h0);
    end
    chk("R7 msb-first byte", {16'd0, buf_q}, {24'd0, pat});

    // R8: word rotate fills high byte, then a byte rotate clears it
    for (int i = 0; i < 12; i++) begin
      run_op("R8 prep", 2'd0, 1'b0, 16'h1, 16'h1);
      run_op("R8 prep", 2'd1, 1'b0, 16'h0, 16'h0);
    end
    run_op("R8 byte rrc clears upper", 2'd1, 1'b1, 16'h0, 16'h0);
    run_op("R8 byte rlc", 2'd2, 1'b1, 16'h0, 16'h0);

    // R11: reserved op
    run_op("R11 reserved", 2'd3, 1'b0, 16'hFFFF, 16'hFFFF);

    // R9: idle cycle holds state and drops done
    @(negedge clk);
    chk("R9 done low idle", {31'd0, done}, 32'd0);
    chk("R9 buf hold", {16'd0, buf_q}, {16'd0, m_buf});

    // random mix
    for (int i = 0; i < 400; i++) begin
      run_op("R1 R6 R7 R8 random", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             16'($urandom), 16'($urandom));
    end

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 reset again", {15'd0, flag_n, flag_z, flag_c, flag_v, buf_q, done}, 32'd0);

    report();
    $finish;
  end
endmodule